// File: doc/BRIEF.md
# Revolution-Count Speed Meter with Duty Regulator

This block closes a speed loop around a motor drive. A sensor that emits one pulse per revolution feeds the block; the pulses are synchronised, rising edges are counted across a fixed gate window, and at the end of every window the count is scaled by 60 to give revolutions per minute. The measured speed is presented with a one-clock valid strobe.

The setpoint arrives as four packed decimal digits. On every completed measurement the block compares the measured speed with the setpoint and nudges a duty command (in whole percent, 0 to 100) toward agreement. The step grows with the error and is capped. When the setpoint changes, or when reset ends, the duty command jumps to a linear estimate of roughly 19.5 rpm per percent, so the loop starts near its operating point. The duty command feeds a separate PWM generator.

Top module: `speed_loop_ctrl`

## Requirements
- R1: The sensor input passes through a chain of SYNC_STAGES flops and only rising edges are counted; a pulse held high for many cycles counts once.
- R2: The gate window is exactly GATE_CYCLES clock cycles long; `rpm_valid` is high for exactly one cycle per window, and consecutive strobes are GATE_CYCLES cycles apart.
- R3: On the strobe, `rpm_out` equals 60 times the number of rising edges in the window just ended; the count saturates at COUNT_MAX, so `rpm_out` never exceeds 60*COUNT_MAX.
- R4: No edge is lost or double-counted across a window boundary: an edge in the last cycle of a window belongs to that window, and the counter restarts from zero for the next.
- R5: The setpoint is decoded from `set_bcd` as 1000*[15:12] + 100*[11:8] + 10*[7:4] + [3:0]; any digit above 9 is taken as 9.
- R6: In the first clock after reset is released, and in the clock after `set_bcd` changes, `duty_pct` loads floor(2*setpoint/39), limited to 100; this load takes priority over an adjustment in the same cycle.
- R7: One clock after a `rpm_valid` strobe, if the measured speed differs from the setpoint, `duty_pct` moves up (measured below setpoint) or down (measured above) by step = min(max(|error| >> STEP_SHIFT, 1), MAX_STEP).
- R8: When the measured speed equals the setpoint, `duty_pct` is left unchanged by the adjustment.
- R9: `duty_pct` stays within 0 to 100: an upward step stops at 100 and a downward step stops at 0.
- R10: `duty_pct` changes only in the clock after a strobe or after a setpoint change (or reset release).
- R11: While reset is asserted, `rpm_out` is 0, `rpm_valid` is 0 and `duty_pct` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_in | input | 1 | Raw one-pulse-per-revolution sensor signal |
| set_bcd | input | 16 | Speed setpoint, four packed decimal digits, thousands in [15:12] |
| rpm_out | output | RPM_W | Measured speed in rpm, updated with the strobe |
| rpm_valid | output | 1 | One-clock strobe marking a new measurement |
| duty_pct | output | 7 | Duty command in percent, 0 to 100 |

## Verification
The bench builds the block with GATE_CYCLES = 400 and COUNT_MAX = 50 while keeping STEP_SHIFT = 5 and MAX_STEP = 8, so a window lasts a few hundred cycles and many complete windows fit in one run. The small COUNT_MAX makes counter saturation reachable with a modest burst of pulses, and the short window lets a burst straddle a boundary to test that edges are split between windows without loss. The default step settings keep both the minimum step of one and the cap of eight reachable with setpoints in the low thousands.

// File: rtl/spdreg_pkg.sv
package spdreg_pkg;

    localparam int DUTY_W      = 7;
    localparam int DUTY_MAX    = 100;
    localparam int SP_W        = 14;
    localparam int RPM_PER_REV = 60;
    localparam int EST_NUM     = 2;
    localparam int EST_DEN     = 39;

    typedef enum logic [1:0] {
        ADJ_HOLD = 2'd0,
        ADJ_UP   = 2'd1,
        ADJ_DOWN = 2'd2
    } adj_dir_e;

    typedef struct packed {
        adj_dir_e            dir;
        logic [DUTY_W-1:0]   step;
    } adj_cmd_t;

    function automatic logic [3:0] digit_lim(input logic [3:0] d);
        return (d > 4'd9) ? 4'd9 : d;
    endfunction

    function automatic logic [SP_W-1:0] bcd_to_bin(input logic [15:0] b);
        logic [SP_W-1:0] acc;
        acc = SP_W'(digit_lim(b[15:12])) * SP_W'(1000)
            + SP_W'(digit_lim(b[11:8]))  * SP_W'(100)
            + SP_W'(digit_lim(b[7:4]))   * SP_W'(10)
            + SP_W'(digit_lim(b[3:0]));
        return acc;
    endfunction

    function automatic logic [DUTY_W-1:0] duty_estimate(input logic [SP_W-1:0] sp);
        logic [SP_W:0] scaled;
        logic [SP_W:0] q;
        scaled = (SP_W+1)'(sp) * (SP_W+1)'(EST_NUM);
        q      = scaled / (SP_W+1)'(EST_DEN);
        return (q > (SP_W+1)'(DUTY_MAX)) ? DUTY_W'(DUTY_MAX) : q[DUTY_W-1:0];
    endfunction

endpackage

// File: rtl/spd_edge_sync.sv
module spd_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic rise
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= raw_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[SYNC_STAGES-1];
    end

    assign rise = chain[SYNC_STAGES-1] & ~prev;
endmodule

// File: rtl/spd_gate_counter.sv
module spd_gate_counter #(
    parameter int GATE_CYCLES = 125_000_000,
    parameter int COUNT_MAX   = 255,
    localparam int TW = (GATE_CYCLES > 1) ? $clog2(GATE_CYCLES) : 1,
    localparam int CW = $clog2(COUNT_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          edge_in,
    output logic [CW-1:0] win_count,
    output logic          win_done
);
    logic [TW-1:0] timer;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_next;
    logic          last_cycle;

    assign last_cycle = (timer == TW'(GATE_CYCLES - 1));
    assign cnt_next   = (edge_in && cnt != CW'(COUNT_MAX)) ? cnt + CW'(1) : cnt;

    always_ff @(posedge clk) begin
        if (rst)             timer <= '0;
        else if (last_cycle) timer <= '0;
        else                 timer <= timer + TW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            win_count <= '0;
            win_done  <= 1'b0;
        end else begin
            win_done <= last_cycle;
            if (last_cycle) begin
                win_count <= cnt_next;
                cnt       <= '0;
            end else begin
                cnt <= cnt_next;
            end
        end
    end
endmodule

// File: rtl/spd_duty_reg.sv
module spd_duty_reg
    import spdreg_pkg::*;
#(
    parameter int RPM_W      = 14,
    parameter int STEP_SHIFT = 5,
    parameter int MAX_STEP   = 8,
    localparam int ERR_W = ((RPM_W > SP_W) ? RPM_W : SP_W) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SP_W-1:0]   setpoint,
    input  logic [RPM_W-1:0]  rpm,
    input  logic              rpm_valid,
    output logic [DUTY_W-1:0] duty
);
    logic [SP_W-1:0]         sp_q;
    logic                    sp_seen;
    logic                    preload_req;
    logic signed [ERR_W-1:0] err;
    logic [ERR_W-1:0]        mag;
    logic [ERR_W-1:0]        step_raw;
    logic [ERR_W-1:0]        step_w;
    adj_cmd_t                cmd;
    logic [ERR_W-1:0]        up_sum;
    logic [DUTY_W-1:0]       adj_duty;

    assign preload_req = !sp_seen || (setpoint != sp_q);

    always_comb begin
        err      = $signed(ERR_W'(setpoint)) - $signed(ERR_W'(rpm));
        mag      = (err < 0) ? ERR_W'(-err) : ERR_W'(err);
        step_raw = mag >> STEP_SHIFT;
        if (step_raw == '0)                    step_w = ERR_W'(1);
        else if (step_raw > ERR_W'(MAX_STEP))  step_w = ERR_W'(MAX_STEP);
        else                                   step_w = step_raw;
        cmd.step = step_w[DUTY_W-1:0];
        if (err > 0)      cmd.dir = ADJ_UP;
        else if (err < 0) cmd.dir = ADJ_DOWN;
        else              cmd.dir = ADJ_HOLD;
    end

    always_comb begin
        up_sum = ERR_W'(duty) + ERR_W'(cmd.step);
        case (cmd.dir)
            ADJ_UP:   adj_duty = (up_sum > ERR_W'(DUTY_MAX)) ? DUTY_W'(DUTY_MAX)
                                                             : up_sum[DUTY_W-1:0];
            ADJ_DOWN: adj_duty = (cmd.step >= duty) ? '0 : duty - cmd.step;
            default:  adj_duty = duty;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q    <= '0;
            sp_seen <= 1'b0;
            duty    <= '0;
        end else begin
            sp_q    <= setpoint;
            sp_seen <= 1'b1;
            if (preload_req)    duty <= duty_estimate(setpoint);
            else if (rpm_valid) duty <= adj_duty;
        end
    end
endmodule

// File: rtl/speed_loop_ctrl.sv
module speed_loop_ctrl
    import spdreg_pkg::*;
#(
    parameter int GATE_CYCLES = 125_000_000,
    parameter int COUNT_MAX   = 255,
    parameter int SYNC_STAGES = 2,
    parameter int STEP_SHIFT  = 5,
    parameter int MAX_STEP    = 8,
    localparam int CW    = $clog2(COUNT_MAX + 1),
    localparam int RPM_W = $clog2(COUNT_MAX * RPM_PER_REV + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sense_in,
    input  logic [15:0]       set_bcd,
    output logic [RPM_W-1:0]  rpm_out,
    output logic              rpm_valid,
    output logic [DUTY_W-1:0] duty_pct
);
    logic            rise;
    logic [CW-1:0]   win_count;
    logic            win_done;
    logic [SP_W-1:0] setpoint;

    spd_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_in (sense_in),
        .rise   (rise)
    );

    spd_gate_counter #(.GATE_CYCLES(GATE_CYCLES), .COUNT_MAX(COUNT_MAX)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .edge_in   (rise),
        .win_count (win_count),
        .win_done  (win_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rpm_out   <= '0;
            rpm_valid <= 1'b0;
        end else begin
            rpm_valid <= win_done;
            if (win_done) rpm_out <= RPM_W'(win_count) * RPM_W'(RPM_PER_REV);
        end
    end

    assign setpoint = bcd_to_bin(set_bcd);

    spd_duty_reg #(.RPM_W(RPM_W), .STEP_SHIFT(STEP_SHIFT), .MAX_STEP(MAX_STEP)) u_reg (
        .clk       (clk),
        .rst       (rst),
        .setpoint  (setpoint),
        .rpm       (rpm_out),
        .rpm_valid (rpm_valid),
        .duty      (duty_pct)
    );
endmodule

// File: rtl/speed_loop_ctrl_chk.sv
module speed_loop_ctrl_chk #(
    parameter int GATE_CYCLES = 125_000_000,
    parameter int COUNT_MAX   = 255,
    parameter int RPM_W       = 14
) (
    input logic             clk,
    input logic             rst,
    input logic [15:0]      set_bcd,
    input logic [RPM_W-1:0] rpm_out,
    input logic             rpm_valid,
    input logic [6:0]       duty_pct
);
    int unsigned gap;
    logic        seen_valid;
    int unsigned cyc;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap        <= 0;
            seen_valid <= 1'b0;
            cyc        <= 0;
        end else begin
            if (cyc < 8) cyc <= cyc + 1;
            if (rpm_valid) begin
                gap        <= 1;
                seen_valid <= 1'b1;
            end else begin
                gap <= gap + 1;
            end
        end
    end

    // R2: strobe lasts one cycle
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
        rpm_valid |=> !rpm_valid);

    // R2: strobes spaced by the window length
    p_window_len_r2: assert property (@(posedge clk) disable iff (rst)
        (rpm_valid && seen_valid) |-> gap == GATE_CYCLES);

    // R3: reported speed is a multiple of 60 within the saturated range
    p_rpm_scaled_r3: assert property (@(posedge clk) disable iff (rst)
        rpm_valid |-> (rpm_out % 60 == 0) && (int'(rpm_out) <= COUNT_MAX * 60));

    // R9: duty within range
    p_duty_range_r9: assert property (@(posedge clk) disable iff (rst)
        duty_pct <= 7'd100);

    // R10: duty held unless strobe or setpoint change preceded
    p_duty_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 3 && !$past(rpm_valid) && $past(set_bcd) == $past(set_bcd, 2))
        |-> duty_pct == $past(duty_pct));
endmodule

bind speed_loop_ctrl speed_loop_ctrl_chk #(
    .GATE_CYCLES(GATE_CYCLES),
    .COUNT_MAX  (COUNT_MAX),
    .RPM_W      (RPM_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .set_bcd   (set_bcd),
    .rpm_out   (rpm_out),
    .rpm_valid (rpm_valid),
    .duty_pct  (duty_pct)
);

// File: tb/speed_loop_ctrl_bench.sv
module speed_loop_ctrl_bench;
    localparam int GATE  = 400;
    localparam int CMAX  = 50;
    localparam int SHIFT = 5;
    localparam int MSTEP = 8;
    localparam int RPM_W = $clog2(CMAX * 60 + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sense_in = 1'b0;
    logic [15:0]      set_bcd = 16'h1000;
    logic [RPM_W-1:0] rpm_out;
    logic             rpm_valid;
    logic [6:0]       duty_pct;

    int checks = 0;
    int errors = 0;
    int sp_val = 1000;

    always #4 clk = ~clk;

    speed_loop_ctrl #(
        .GATE_CYCLES(GATE), .COUNT_MAX(CMAX), .SYNC_STAGES(2),
        .STEP_SHIFT(SHIFT), .MAX_STEP(MSTEP)
    ) u_speed_loop_ctrl (
        .clk(clk), .rst(rst), .sense_in(sense_in), .set_bcd(set_bcd),
        .rpm_out(rpm_out), .rpm_valid(rpm_valid), .duty_pct(duty_pct)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int estimate(input int sp);
        int q = (2 * sp) / 39;
        return (q > 100) ? 100 : q;
    endfunction

    function automatic int adjust(input int d, input int sp, input int rpm);
        int e = sp - rpm;
        int m = (e < 0) ? -e : e;
        int s = m >> SHIFT;
        if (e == 0) return d;
        if (s == 0) s = 1;
        if (s > MSTEP) s = MSTEP;
        if (e > 0) return (d + s > 100) ? 100 : d + s;
        return (s >= d) ? 0 : d - s;
    endfunction

    task automatic wait_valid();
        @(negedge clk);
        while (!rpm_valid) @(negedge clk);
    endtask

    task automatic pulses(input int n, input int hi, input int lo);
        for (int i = 0; i < n; i++) begin
            sense_in = 1'b1;
            repeat (hi) @(negedge clk);
            sense_in = 1'b0;
            repeat (lo) @(negedge clk);
        end
    endtask

    // At a strobe: check rpm, then check adjusted duty one clock later.
    task automatic finish_window(input int exp_rpm, input string req);
        int d0;
        wait_valid();
        check(rpm_out == exp_rpm, {req, " rpm"}, rpm_out, exp_rpm);
        d0 = duty_pct;
        @(negedge clk);
        check(rpm_valid == 1'b0, "R2 strobe width", rpm_valid, 0);
        check(duty_pct == adjust(d0, sp_val, exp_rpm), {req, " duty"}, duty_pct,
              adjust(d0, sp_val, exp_rpm));
    endtask

    // At a strobe: change setpoint, check preload one clock later.
    task automatic new_setpoint(input logic [15:0] b, input int val, input string req);
        wait_valid();
        set_bcd = b;
        sp_val  = val;
        @(negedge clk);
        check(duty_pct == estimate(val), req, duty_pct, estimate(val));
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        check(rpm_out == 0,   "R11 rpm in reset", rpm_out, 0);
        check(rpm_valid == 0, "R11 valid in reset", rpm_valid, 0);
        check(duty_pct == 0,  "R11 duty in reset", duty_pct, 0);
        rst = 1'b0;
        @(negedge clk);
        check(duty_pct == 51, "R6 preload after reset", duty_pct, 51);
    endtask

    task automatic t_window();
        int n = 0;
        finish_window(0, "R7 zero count step cap");
        while (!rpm_valid) begin
            @(negedge clk);
            n++;
        end
        check(n == GATE - 1, "R2 window length", n + 1, GATE);
        check(rpm_out == 0, "R3 empty window", rpm_out, 0);
        @(negedge clk);
        check(duty_pct == 67, "R7 second up step", duty_pct, 67);
    endtask

    task automatic t_count();
        int mid;
        pulses(17, 2, 2);
        mid = duty_pct;
        repeat (20) @(negedge clk);
        check(duty_pct == mid, "R10 duty held mid window", duty_pct, mid);
        finish_window(1020, "R7 small error step one");
    endtask

    task automatic t_equal();
        new_setpoint(16'h1020, 1020, "R6 preload on change");
        pulses(17, 3, 3);
        finish_window(1020, "R8 equal speed hold");
    endtask

    task automatic t_hold_high();
        sense_in = 1'b1;
        repeat (150) @(negedge clk);
        sense_in = 1'b0;
        finish_window(60, "R1 long high counts once");
    endtask

    task automatic t_saturate();
        pulses(60, 2, 2);
        finish_window(CMAX * 60, "R3 count saturation");
    endtask

    task automatic t_boundary();
        int r1 = 0;
        int r2 = 0;
        fork
            pulses(60, 5, 5);
            begin
                wait_valid();
                r1 = rpm_out;
                @(negedge clk);
                wait_valid();
                r2 = rpm_out;
            end
        join
        check(r1 > 0 && r2 > 0, "R4 burst straddles boundary", r2, 1);
        check(r1 + r2 == 3600, "R4 no edge lost", r1 + r2, 3600);
        @(negedge clk);
    endtask

    task automatic t_clamp();
        new_setpoint(16'h9999, 9999, "R6 preload limit 100");
        finish_window(0, "R9 clamp at 100");
        new_setpoint(16'h0050, 50, "R6 preload small");
        pulses(10, 2, 2);
        finish_window(600, "R9 clamp at 0");
        pulses(10, 2, 2);
        finish_window(600, "R9 stays at 0");
    endtask

    task automatic t_digit();
        new_setpoint(16'h0A00, 900, "R5 digit above nine");
        check(duty_pct == 46, "R5 decoded 900", duty_pct, 46);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_window();
                t_count();
                t_equal();
                t_hold_high();
                t_saturate();
                t_boundary();
                t_clamp();
                t_digit();
            end
            begin
                repeat (100_000) @(posedge clk);
                check(1'b0, "watchdog", 0, 1);
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule